// File: doc/BRIEF.md
# Per-Bit Sampler Offset Calibration Sequencer

This block trims the 4-bit offset code of each receiver sampler on a data byte. While the line rests at mid-supply, it steps one shared offset code upward through every nonzero value. For each value it holds the samplers in training mode for a settling interval and then takes one snapshot of every lane's sampled output. Each lane keeps two codes: the highest one that gave a one and the lowest one that gave a zero. When the sweep ends, every lane's trim is set to the point halfway between these two codes. A lane that never changes value is pushed to the rail that matches its behaviour.

Software or a training controller pulses `start` and waits for `done`. The packed trim word for the eight data lanes and, in low-power mode, the separate trim for the strobe lane then remain on the outputs until the next run ends. During the sweep, `sweep_word` carries the current shared code to the analog samplers, and `train_en` enables their training mode.

Top module: `samp_offset_cal`

## Requirements
- R1: During and after reset, `busy`, `done` and `train_en` are low, and `offset_word`, `strobe_code` and `sweep_word` are zero.
- R2: While `train_en` is high, the shared code runs through 1, 2, …, 15 in ascending order, one value per step. `sweep_word` carries the code in every 4-bit field, with lane n in bits [4n+3:4n].
- R3: For each code, `train_en` is high for exactly SETTLE_CYC consecutive cycles and then low for one cycle. `busy` stays high from the cycle after `start` is accepted until `done`.
- R4: Feedback is sampled only in the last cycle of each training window. Values on `fb_bits` while `train_en` is low have no effect on the results.
- R5: A lane that samples one records the current code as its last-one code. A lane that samples zero records the current code as its first-zero code only if no first-zero code has been recorded yet. Both records are cleared when a run starts.
- R6: A lane that recorded both a one and a zero gets trim (first_zero + last_one) / 2, rounded down and limited to 0..15. This also holds when the lane's feedback is not monotonic.
- R7: A lane that never sampled zero gets trim 15.
- R8: A lane that never sampled one gets trim 0. This rule takes precedence over R7.
- R9: When `lp_mode` is high at the accepted `start`, lane 8 (`fb_bits[8]`, the strobe) is trained by the same rules and its trim appears on `strobe_code`. Otherwise `strobe_code` becomes 0 at the end of the run, whatever `fb_bits[8]` shows.
- R10: `done` is a one-cycle pulse. It comes two cycles after the last training window closes, with `busy` low. `offset_word` and `strobe_code` change only in the cycle `done` is high.
- R11: A `start` pulse while `busy` is high is ignored. The running sweep continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (accepted when idle) |
| lp_mode | input | 1 | Also train the strobe lane for this run |
| fb_bits | input | 9 | Sampled sampler outputs; bit 8 is the strobe lane |
| train_en | output | 1 | Sampler training mode enable |
| sweep_word | output | 32 | Current shared code replicated per lane |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| offset_word | output | 32 | Packed per-lane trim codes, lane n at [4n+3:4n] |
| strobe_code | output | 4 | Trim code for the strobe lane |

## Verification
The hardest case to reach from the ports is a lane whose feedback is not monotonic, together with lanes that saturate at either rail in the same run. Here first-zero and last-one are far apart or even reversed, so the precedence rules decide the result. The bench gives each lane its own table that maps the sweep code to a sample value. It drives `fb_bits` from `sweep_word` and inverts the tables whenever `train_en` is low, so any sampling outside the training window shows up as a wrong trim. Further runs send `start` pulses into a sweep that is already in progress, and they alternate `lp_mode` to show that the strobe lane is used only when low-power mode is requested.

// File: rtl/sot_pkg.sv
package sot_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned CODE_LAST = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_GAP    = 2'd2,
    ST_FINAL  = 2'd3
  } sot_state_e;

  // Trim for one lane from its recorded codes; 0 means "never recorded".
  function automatic logic [CODE_W-1:0] sot_mid(input logic [CODE_W-1:0] first_zero,
                                                input logic [CODE_W-1:0] last_one);
    logic [CODE_W:0] sum;
    sum = {1'b0, first_zero} + {1'b0, last_one};
    if (last_one == '0)        return '0;
    else if (first_zero == '0) return CODE_W'(CODE_LAST);
    else                       return sum[CODE_W:1];
  endfunction

endpackage

// File: rtl/sot_seq.sv
module sot_seq
  import sot_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [CODE_W-1:0] code,
  output logic              train_en,
  output logic              busy,
  output logic              clear,
  output logic              sample,
  output logic              finish,
  output logic              done
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYC) + 1;

  sot_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             win_last;

  assign win_last = (cnt == CNT_W'(SETTLE_CYC - 1));
  assign train_en = (state == ST_SETTLE);
  assign busy     = (state != ST_IDLE);
  assign clear    = (state == ST_IDLE) && start;
  assign sample   = train_en && win_last;
  assign finish   = (state == ST_FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      code  <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SETTLE;
            cnt   <= '0;
            code  <= CODE_W'(1);
          end
        end
        ST_SETTLE: begin
          if (win_last) state <= ST_GAP;
          else          cnt   <= cnt + 1'b1;
        end
        ST_GAP: begin
          if (code == CODE_W'(CODE_LAST)) begin
            state <= ST_FINAL;
          end else begin
            code  <= code + 1'b1;
            cnt   <= '0;
            state <= ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sot_bit_track.sv
module sot_bit_track
  import sot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              fb,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] first_zero,
  output logic [CODE_W-1:0] last_one
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_zero <= '0;
      last_one   <= '0;
    end else if (clear) begin
      first_zero <= '0;
      last_one   <= '0;
    end else if (sample) begin
      if (fb)                       last_one   <= code;
      else if (first_zero == '0)    first_zero <= code;
    end
  end

endmodule

// File: rtl/sot_pack.sv
module sot_pack
  import sot_pkg::*;
#(
  parameter int unsigned LANES = 9
) (
  input  logic [LANES*CODE_W-1:0] fz_v,
  input  logic [LANES*CODE_W-1:0] lo_v,
  output logic [LANES*CODE_W-1:0] trim_v
);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign trim_v[b*CODE_W +: CODE_W] = sot_mid(fz_v[b*CODE_W +: CODE_W],
                                                lo_v[b*CODE_W +: CODE_W]);
  end

endmodule

// File: rtl/samp_offset_cal.sv
module samp_offset_cal
  import sot_pkg::*;
#(
  parameter int unsigned NUM_BITS   = 8,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       lp_mode,
  input  logic [NUM_BITS:0]          fb_bits,
  output logic                       train_en,
  output logic [NUM_BITS*CODE_W-1:0] sweep_word,
  output logic                       busy,
  output logic                       done,
  output logic [NUM_BITS*CODE_W-1:0] offset_word,
  output logic [CODE_W-1:0]          strobe_code
);

  localparam int unsigned LANES  = NUM_BITS + 1;
  localparam int unsigned WORD_W = NUM_BITS * CODE_W;

  logic [CODE_W-1:0]       sweep_code;
  logic                    clear;
  logic                    sample_fire;
  logic                    finish;
  logic                    lp_q;
  logic [LANES*CODE_W-1:0] fz_v;
  logic [LANES*CODE_W-1:0] lo_v;
  logic [LANES*CODE_W-1:0] trim_v;

  sot_seq #(.SETTLE_CYC(SETTLE_CYC)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .code     (sweep_code),
    .train_en (train_en),
    .busy     (busy),
    .clear    (clear),
    .sample   (sample_fire),
    .finish   (finish),
    .done     (done)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_trk
    sot_bit_track i_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .sample     (sample_fire),
      .fb         (fb_bits[b]),
      .code       (sweep_code),
      .first_zero (fz_v[b*CODE_W +: CODE_W]),
      .last_one   (lo_v[b*CODE_W +: CODE_W])
    );
  end

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_rep
    assign sweep_word[b*CODE_W +: CODE_W] = sweep_code;
  end

  sot_pack #(.LANES(LANES)) i_pack (
    .fz_v   (fz_v),
    .lo_v   (lo_v),
    .trim_v (trim_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q        <= 1'b0;
      offset_word <= '0;
      strobe_code <= '0;
    end else begin
      if (clear) lp_q <= lp_mode;
      if (finish) begin
        offset_word <= trim_v[WORD_W-1:0];
        strobe_code <= lp_q ? trim_v[WORD_W +: CODE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sot_chk.sv
module sot_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              train_en,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] sweep_word,
  input logic [WORD_W-1:0] offset_word,
  input logic              sample_fire,
  input logic [3:0]        sweep_code
);

  // R2
  code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |-> sweep_word[3:0] != 4'd0);

  // R2
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(train_en) && $past(busy)) |-> sweep_code == 4'($past(sweep_code) + 4'd1));

  // R2
  word_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |-> sweep_word[WORD_W-1:WORD_W-4] == sweep_code);

  // R3
  gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(train_en) |-> busy);

  // R4
  sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_fire |-> train_en);

  // R4
  sample_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_fire |=> !train_en);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(offset_word));

endmodule

bind samp_offset_cal sot_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .train_en    (train_en),
  .busy        (busy),
  .done        (done),
  .sweep_word  (sweep_word),
  .offset_word (offset_word),
  .sample_fire (sample_fire),
  .sweep_code  (sweep_code)
);

// File: tb/test_samp_offset_cal.sv
module test_samp_offset_cal;

  localparam int CLK_P  = 10;
  localparam int SETTLE = 5;
  localparam int NB     = 8;

  typedef struct {
    bit en;
    bit bsy;
    bit dn;
    int code;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        lp_mode = 1'b0;
  logic [8:0]  fb_bits;
  logic        train_en;
  logic [31:0] sweep_word;
  logic        busy;
  logic        done;
  logic [31:0] offset_word;
  logic [3:0]  strobe_code;

  logic [15:0] one_mask [9];
  exp_t        q [$];
  int          total = 0;
  int          bad = 0;
  logic [31:0] m_word = '0;
  logic [3:0]  m_strobe = '0;
  logic [31:0] pend_word;
  logic [3:0]  pend_strobe;
  string       tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  samp_offset_cal #(.NUM_BITS(NB), .SETTLE_CYC(SETTLE)) i_samp_offset_cal (
    .clk, .rst_n, .start, .lp_mode, .fb_bits, .train_en, .sweep_word,
    .busy, .done, .offset_word, .strobe_code
  );

  // Feedback follows each lane's table during training, its inverse otherwise (R4).
  always_comb begin
    for (int b = 0; b < 9; b++)
      fb_bits[b] = train_en ? one_mask[b][sweep_word[3:0]] : ~one_mask[b][sweep_word[3:0]];
  end

  function automatic int exp_trim(input logic [15:0] m);
    int hi_one = -1;
    int lo_zero = -1;
    for (int c = 15; c >= 1; c--) if (m[c] && hi_one < 0) hi_one = c;
    for (int c = 1; c <= 15; c++) if (!m[c] && lo_zero < 0) lo_zero = c;
    if (hi_one < 0) return 0;
    if (lo_zero < 0) return 15;
    return (hi_one + lo_zero) / 2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build_run(input bit lp);
    for (int c = 1; c <= 15; c++) begin
      for (int k = 0; k < SETTLE; k++) q.push_back('{1, 1, 0, c});
      q.push_back('{0, 1, 0, c});
    end
    q.push_back('{0, 1, 0, 15});
    q.push_back('{0, 0, 1, 15});
    for (int b = 0; b < NB; b++) pend_word[b*4 +: 4] = 4'(exp_trim(one_mask[b]));
    pend_strobe = lp ? 4'(exp_trim(one_mask[8])) : 4'd0;
  endtask

  // One cycle: compare against the model for the edge just passed, then drive.
  task automatic step(input bit st, input bit lp);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = '{0, 0, 0, 0};
    if (e.dn) begin
      m_word   = pend_word;
      m_strobe = pend_strobe;
    end
    chk("R3", 32'(train_en), 32'(e.en), "train_en");
    chk("R3", 32'(busy), 32'(e.bsy), "busy");
    chk("R10", 32'(done), 32'(e.dn), "done");
    if (e.en) chk("R2", sweep_word, {8{4'(e.code)}}, "sweep_word");
    chk(tag, offset_word, m_word, "offset_word");
    chk("R9", 32'(strobe_code), 32'(m_strobe), "strobe_code");
    start   = st;
    lp_mode = lp;
    if (st && q.size() == 0) build_run(lp);
  endtask

  task automatic run(input bit lp, input bit poke);
    int n = 0;
    step(1'b1, lp);
    while (q.size() > 0) begin
      n++;
      step(poke && (n % 37 == 0), poke ? ~lp : lp);
    end
    step(1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 9; b++) one_mask[b] = '0;
    #(CLK_P * 3 + 1);
    // R1: reset values
    chk("R1", 32'({busy, done, train_en}), 32'd0, "ctl in reset");
    chk("R1", offset_word, 32'd0, "offset_word in reset");
    chk("R1", sweep_word, 32'd0, "sweep_word in reset");
    chk("R1", 32'(strobe_code), 32'd0, "strobe_code in reset");
    rst_n = 1'b1;
    repeat (2) step(1'b0, 1'b0);

    // R5 R6: monotonic thresholds, one below lane-specific code
    tag = "R5 R6";
    for (int b = 0; b < 9; b++)
      for (int c = 0; c < 16; c++) one_mask[b][c] = (c < 2 + b + (b / 2));
    run(1'b0, 1'b0);

    // R7 R8 R6 R9: rails, precedence, non-monotonic lanes, strobe trained
    tag = "R7 R8 R6";
    one_mask[0] = 16'hFFFF;               // never zero -> 15 (R7)
    one_mask[1] = 16'h0000;               // never one  -> 0  (R8)
    one_mask[2] = 16'h0208;               // one at 3,9; fz=1 -> 5
    one_mask[3] = 16'h8000;               // one only at 15 -> 8
    one_mask[4] = 16'hFFFD;               // zero only at 1 -> (1+15)/2=8
    one_mask[5] = 16'h0002;               // one only at 1 -> (2+1)/2=1
    one_mask[6] = 16'h7FFE;               // ones 1..14, zero 15 -> 14
    one_mask[7] = 16'h00F0;               // ones 4..7, fz=1 -> 4
    one_mask[8] = 16'h003E;               // strobe: ones 1..5 -> 5
    run(1'b1, 1'b0);

    // R9: strobe ignored without low-power mode; R4 via inverted idle feedback
    tag = "R9 R4";
    one_mask[8] = 16'hFFFF;
    run(1'b0, 1'b0);

    // R11: stray start pulses (and toggling lp_mode) during the sweep
    tag = "R11";
    for (int b = 0; b < 9; b++)
      for (int c = 0; c < 16; c++) one_mask[b][c] = (c < 15 - b);
    run(1'b1, 1'b1);

    // R8 R5: all lanes never one
    tag = "R8 R5";
    for (int b = 0; b < 9; b++) one_mask[b] = '0;
    run(1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule